// File: doc/BRIEF.md
# AXI4 Protocol Compliance Monitor

A passive checker that watches all five AXI4 channels between one manager and one subordinate and reports rule violations. It drives nothing on the bus. Each detected violation sets a sticky bit in an error vector, and the index of the first violation seen is latched as an error code. Both are cleared only by the active-low reset.

The monitor covers four groups of rules. It checks that handshakes hold steady while a channel is stalled. It checks that every accepted read or write address describes a legal burst: burst type, length, size, wrap alignment and 4KB crossing. It counts write-data beats against the accepted write lengths and checks that write responses come after their data. It follows read-data beats against the accepted read lengths. Transfers are counted only at rising edges where valid and ready are both high.

Up to `DEPTH` accepted but unfinished bursts are tracked per queue. The monitor assumes responses come back in acceptance order; IDs only take part in the stability check.

Top module: `axi4_protocol_monitor`

## Requirements
- R1: If a channel's valid was high and its ready low at one edge, and valid is low at the next edge, error bit 0 is set.
- R2: If any payload field of a stalled channel (valid high, ready low at the previous edge) differs while valid is still high, error bit 1 is set.
- R3: An accepted address whose burst field is 2'b11 sets bit 2. The legal encodings are 2'b00 FIXED, 2'b01 INCR and 2'b10 WRAP.
- R4: Bit 3 is set in two cases. (a) A FIXED or WRAP burst has a length field above 15. (b) A WRAP burst has a length field other than 1, 3, 7 or 15, that is 2, 4, 8 or 16 beats. INCR lengths 0 to 255 (1 to 256 beats) are legal.
- R5: A WRAP burst whose start address is not a multiple of the beat size sets bit 4.
- R6: A size field above log2(DATA_W/8) sets bit 5.
- R7: Bit 6 is set for an INCR burst that crosses a 4KB boundary. This means the start address, aligned down to the beat size, plus (length+1)·2^size bytes is greater than 4096 within its 4KB page. A burst that ends exactly on the boundary is legal.
- R8: Bit 7 is set in two cases. (a) The beat count of a write-data burst, closed by its last flag, differs from the length of the write address it pairs with. Bursts pair in order, so interleaved data is caught this way. (b) 256 beats arrive without a last flag. Write data may arrive before its address.
- R9: A write response accepted while no write burst has both its address and all its data accepted sets bit 8. A response in the very cycle the pairing completes is legal.
- R10: Read data accepted while no read address is outstanding sets bit 9. This includes an address accepted in the same cycle.
- R11: A read beat whose last flag is missing on the final beat, or present on an earlier beat, sets bit 10.
- R12: An address or write-data burst arriving while its tracking queue of DEPTH entries is full sets bit 11.
- R13: Error bits never clear before reset. `err_any` is the OR of all bits. `err_first` holds the lowest-numbered bit among those set in the first cycle any error appeared, and then stays fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| aw_addr | input | ADDR_W | Write start address |
| aw_len | input | 8 | Write beats minus one |
| aw_size | input | 3 | Write log2 bytes per beat |
| aw_burst | input | 2 | Write burst type |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Write byte strobes |
| w_last | input | 1 | Final write beat |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | input | ID_W | Write response ID |
| b_resp | input | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read address ID |
| ar_addr | input | ADDR_W | Read start address |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | Read log2 bytes per beat |
| ar_burst | input | 2 | Read burst type |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | ID_W | Read data ID |
| r_data | input | DATA_W | Read data |
| r_resp | input | 2 | Read response code |
| r_last | input | 1 | Final read beat |
| err_flags | output | 12 | Sticky one-hot error bits |
| err_first | output | 4 | Index of first error |
| err_any | output | 1 | Any error recorded |

## Verification
Two checks can fall in the same cycle. One is the write-response check. The other is the pairing of a finished write-data burst with its queued address, which makes the response legal. The bench drives the last write beat and then, in the very next cycle, the response handshake. At that edge the pairing and the response land together, and the bench expects no flag. A companion case sends a response with no write at all and expects bit 8.

// File: rtl/axi4_mon_lenq.sv
module axi4_mon_lenq #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  wire do_pop  = pop && !empty;
  wire do_push = push && (!full || do_pop);

  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign dout  = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) if (do_push) mem[wp] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PW+1)'(DEPTH));
endmodule

// File: rtl/axi4_protocol_monitor.sv
module axi4_protocol_monitor #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                aw_valid,
  input  logic                aw_ready,
  input  logic [ID_W-1:0]     aw_id,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic [7:0]          aw_len,
  input  logic [2:0]          aw_size,
  input  logic [1:0]          aw_burst,
  input  logic                w_valid,
  input  logic                w_ready,
  input  logic [DATA_W-1:0]   w_data,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_last,
  input  logic                b_valid,
  input  logic                b_ready,
  input  logic [ID_W-1:0]     b_id,
  input  logic [1:0]          b_resp,
  input  logic                ar_valid,
  input  logic                ar_ready,
  input  logic [ID_W-1:0]     ar_id,
  input  logic [ADDR_W-1:0]   ar_addr,
  input  logic [7:0]          ar_len,
  input  logic [2:0]          ar_size,
  input  logic [1:0]          ar_burst,
  input  logic                r_valid,
  input  logic                r_ready,
  input  logic [ID_W-1:0]     r_id,
  input  logic [DATA_W-1:0]   r_data,
  input  logic [1:0]          r_resp,
  input  logic                r_last,
  output logic [11:0]         err_flags,
  output logic [3:0]          err_first,
  output logic                err_any
);
  localparam int NERR     = 12;
  localparam int MAX_SIZE = $clog2(DATA_W/8);
  localparam int AWP_W    = ID_W + ADDR_W + 13;
  localparam int WP_W     = DATA_W + DATA_W/8 + 1;
  localparam int BP_W     = ID_W + 2;
  localparam int RP_W     = ID_W + DATA_W + 3;
  localparam logic [1:0] BT_FIXED = 2'b00, BT_INCR = 2'b01, BT_WRAP = 2'b10;

  wire aw_hs = aw_valid && aw_ready;
  wire w_hs  = w_valid && w_ready;
  wire b_hs  = b_valid && b_ready;
  wire ar_hs = ar_valid && ar_ready;
  wire r_hs  = r_valid && r_ready;

  // stall tracking: a channel is held if valid && !ready at the last edge
  wire [4:0] vld = {r_valid, ar_valid, b_valid, w_valid, aw_valid};
  wire [4:0] rdy = {r_ready, ar_ready, b_ready, w_ready, aw_ready};
  wire [AWP_W-1:0] aw_pl = {aw_id, aw_addr, aw_len, aw_size, aw_burst};
  wire [WP_W-1:0]  w_pl  = {w_data, w_strb, w_last};
  wire [BP_W-1:0]  b_pl  = {b_id, b_resp};
  wire [AWP_W-1:0] ar_pl = {ar_id, ar_addr, ar_len, ar_size, ar_burst};
  wire [RP_W-1:0]  r_pl  = {r_id, r_data, r_resp, r_last};
  logic [4:0] held_q;
  logic [AWP_W-1:0] aw_pl_q, ar_pl_q;
  logic [WP_W-1:0]  w_pl_q;
  logic [BP_W-1:0]  b_pl_q;
  logic [RP_W-1:0]  r_pl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      aw_pl_q <= '0; w_pl_q <= '0; b_pl_q <= '0; ar_pl_q <= '0; r_pl_q <= '0;
    end else begin
      held_q <= vld & ~rdy;
      aw_pl_q <= aw_pl; w_pl_q <= w_pl; b_pl_q <= b_pl; ar_pl_q <= ar_pl; r_pl_q <= r_pl;
    end
  end

  wire [4:0] chg = {r_pl != r_pl_q, ar_pl != ar_pl_q, b_pl != b_pl_q,
                    w_pl != w_pl_q, aw_pl != aw_pl_q};
  wire e_drop = |(held_q & ~vld);
  wire e_chg  = |(held_q & vld & chg);

  // burst legality: {cross4k, size, wrap_align, length, type}
  function automatic logic [4:0] burst_chk(input logic [11:0] a, input logic [7:0] len,
                                           input logic [2:0] sz, input logic [1:0] bt);
    logic [11:0] m;
    logic [16:0] span;
    logic bad_len;
    m = (12'd1 << sz) - 12'd1;
    span = {5'd0, a & ~m} + (({9'd0, len} + 17'd1) << sz);
    bad_len = (bt != BT_INCR && len > 8'd15) ||
              (bt == BT_WRAP && len != 8'd1 && len != 8'd3 && len != 8'd7 && len != 8'd15);
    return {bt == BT_INCR && span > 17'd4096,
            sz > 3'(MAX_SIZE),
            bt == BT_WRAP && (a & m) != 12'd0,
            bad_len,
            bt == 2'b11};
  endfunction

  wire [4:0] aw_bad = aw_hs ? burst_chk(aw_addr[11:0], aw_len, aw_size, aw_burst) : 5'd0;
  wire [4:0] ar_bad = ar_hs ? burst_chk(ar_addr[11:0], ar_len, ar_size, ar_burst) : 5'd0;

  // write side: address lengths and closed data-burst lengths pair in order
  logic [7:0] awq_len, wq_len, arq_len, w_cnt, r_beat, done_cnt;
  logic awq_empty, awq_full, wq_empty, wq_full, arq_empty, arq_full;
  wire pair  = !awq_empty && !wq_empty;
  wire wpush = w_hs && w_last;

  axi4_mon_lenq #(.DEPTH(DEPTH), .W(8)) u_awq (.clk(clk), .rst_n(rst_n), .push(aw_hs),
    .pop(pair), .din(aw_len), .dout(awq_len), .empty(awq_empty), .full(awq_full));
  axi4_mon_lenq #(.DEPTH(DEPTH), .W(8)) u_wq (.clk(clk), .rst_n(rst_n), .push(wpush),
    .pop(pair), .din(w_cnt), .dout(wq_len), .empty(wq_empty), .full(wq_full));

  wire e_wlen = (pair && awq_len != wq_len) || (w_hs && !w_last && w_cnt == 8'hFF);
  wire b_ok   = (done_cnt != 8'd0) || pair;
  wire e_b    = b_hs && !b_ok;

  // read side
  wire r_final = r_beat == arq_len;
  wire r_pop   = r_hs && !arq_empty && (r_final || r_last);
  wire e_rorph = r_hs && arq_empty;
  wire e_rlast = r_hs && !arq_empty && (r_last != r_final);

  axi4_mon_lenq #(.DEPTH(DEPTH), .W(8)) u_arq (.clk(clk), .rst_n(rst_n), .push(ar_hs),
    .pop(r_pop), .din(ar_len), .dout(arq_len), .empty(arq_empty), .full(arq_full));

  wire e_ovf = (aw_hs && awq_full && !pair) || (wpush && wq_full && !pair) ||
               (ar_hs && arq_full && !r_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_cnt <= '0; r_beat <= '0; done_cnt <= '0;
    end else begin
      if (w_hs) w_cnt <= w_last ? 8'd0 : w_cnt + 8'd1;
      if (r_hs && !arq_empty) r_beat <= r_pop ? 8'd0 : r_beat + 8'd1;
      done_cnt <= done_cnt + {7'd0, pair} - {7'd0, b_hs && b_ok};
    end
  end

  // error recording
  wire [NERR-1:0] new_err = {e_ovf, e_rlast, e_rorph, e_b, e_wlen,
                             aw_bad | ar_bad, e_chg, e_drop};

  function automatic logic [3:0] lowest(input logic [NERR-1:0] v);
    logic [3:0] idx;
    idx = '0;
    for (int i = NERR-1; i >= 0; i--) if (v[i]) idx = 4'(i);
    return idx;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0; err_first <= '0;
    end else begin
      err_flags <= err_flags | new_err;
      if (err_flags == '0 && new_err != '0) err_first <= lowest(new_err);
    end
  end
  assign err_any = |err_flags;

  a_r1_drop_ar: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ar_valid && !ar_ready) && !ar_valid) |=> err_flags[0]);
  a_r3_rsvd_type: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready && aw_burst == 2'b11) |=> err_flags[2]);
  a_r9_resp_early: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_ready && done_cnt == 8'd0 && awq_empty) |=> err_flags[8]);
  a_r12_aw_full: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready && awq_full && wq_empty) |=> err_flags[11]);
  a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_flags) & ~err_flags) == '0);
  a_r13_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_any) |-> $stable(err_first));
  a_r13_first_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> err_flags[err_first]);
endmodule

// File: tb/tb_axi4_protocol_monitor.sv
module tb_axi4_protocol_monitor;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
  logic b_valid = 0, b_ready = 0, ar_valid = 0, ar_ready = 0;
  logic r_valid = 0, r_ready = 0, r_last = 0;
  logic [3:0] aw_id = 0, b_id = 0, ar_id = 0, r_id = 0;
  logic [31:0] aw_addr = 0, ar_addr = 0, w_data = 0, r_data = 0;
  logic [7:0] aw_len = 0, ar_len = 0;
  logic [2:0] aw_size = 0, ar_size = 0;
  logic [1:0] aw_burst = 0, ar_burst = 0, b_resp = 0, r_resp = 0;
  logic [3:0] w_strb = 4'hF;
  logic [11:0] err_flags;
  logic [3:0] err_first;
  logic err_any;

  axi4_protocol_monitor dut (.*);

  int total = 0, bad = 0;
  logic [11:0] exp_flags = 0;
  string cur_req = "R13";
  bit live = 0, done = 0;

  // every clock: the design may never report a bit the model does not allow
  always @(negedge clk) if (live && rst_n) begin
    total++;
    if ((err_flags & ~exp_flags) != 0) begin
      bad++;
      $display("FAIL %s: unexpected flags actual=%h expected=%h", cur_req, err_flags, exp_flags);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic begin_case(input string req, input logic [11:0] e);
    live = 0; rst_n = 0; idle(2); rst_n = 1;
    cur_req = req; exp_flags = e; live = 1;
  endtask

  task automatic end_case; idle(4); check(cur_req, 32'(err_flags), 32'(exp_flags)); endtask

  task automatic aw_send(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s, input logic [1:0] bt);
    @(negedge clk); aw_valid = 1; aw_ready = 1; aw_addr = a; aw_len = l; aw_size = s; aw_burst = bt;
    @(negedge clk); aw_valid = 0; aw_ready = 0;
  endtask
  task automatic ar_send(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s, input logic [1:0] bt);
    @(negedge clk); ar_valid = 1; ar_ready = 1; ar_addr = a; ar_len = l; ar_size = s; ar_burst = bt;
    @(negedge clk); ar_valid = 0; ar_ready = 0;
  endtask
  task automatic w_beat(input logic lst);
    @(negedge clk); w_valid = 1; w_ready = 1; w_last = lst; w_data = w_data + 1;
    @(negedge clk); w_valid = 0; w_ready = 0; w_last = 0;
  endtask
  task automatic w_burst(input int n);
    for (int i = 0; i < n; i++) w_beat(i == n-1);
  endtask
  task automatic b_send;
    @(negedge clk); b_valid = 1; b_ready = 1;
    @(negedge clk); b_valid = 0; b_ready = 0;
  endtask
  task automatic r_beat(input logic lst);
    @(negedge clk); r_valid = 1; r_ready = 1; r_last = lst;
    @(negedge clk); r_valid = 0; r_ready = 0; r_last = 0;
  endtask

  initial begin
    // R13 reset state
    begin_case("R13", 12'h000);
    check("R13 reset flags", 32'(err_flags), 0);
    check("R13 reset any", 32'(err_any), 0);
    check("R13 reset code", 32'(err_first), 0);

    // R8/R9 legal write, then data-before-address write
    begin_case("R8", 12'h000);
    aw_send(32'h100, 8'd3, 3'd2, 2'b01); w_burst(4); b_send;
    w_burst(2); aw_send(32'h200, 8'd1, 3'd2, 2'b01); b_send;
    end_case;

    // R9 response in the same cycle the pairing completes
    begin_case("R9", 12'h000);
    aw_send(32'h40, 8'd1, 3'd2, 2'b01); w_beat(0);
    @(negedge clk); w_valid = 1; w_ready = 1; w_last = 1;
    @(negedge clk); w_valid = 0; w_ready = 0; w_last = 0; b_valid = 1; b_ready = 1;
    @(negedge clk); b_valid = 0; b_ready = 0;
    end_case;

    // R9 response with no write at all
    begin_case("R9", 12'h100); b_send; end_case;

    // R2/R11 legal stalled read: valid held, payload steady
    begin_case("R11", 12'h000);
    @(negedge clk); ar_valid = 1; ar_ready = 0; ar_addr = 32'h80; ar_len = 8'd1; ar_size = 3'd2; ar_burst = 2'b01;
    @(negedge clk); ar_ready = 1;
    @(negedge clk); ar_valid = 0; ar_ready = 0;
    r_beat(0); r_beat(1);
    end_case;

    // R1 valid dropped on a stalled read address
    begin_case("R1", 12'h001);
    @(negedge clk); ar_valid = 1; ar_ready = 0;
    @(negedge clk); ar_valid = 0;
    end_case;

    // R2 payload change on stalled write data
    begin_case("R2", 12'h002);
    @(negedge clk); w_valid = 1; w_ready = 0; w_data = 32'h11;
    @(negedge clk); w_data = 32'h22;
    @(negedge clk); w_valid = 0;
    exp_flags = 12'h003;
    end_case;

    // R3 reserved burst type
    begin_case("R3", 12'h004); aw_send(32'h0, 8'd0, 3'd2, 2'b11); end_case;

    // R4 FIXED length boundary and long INCR
    begin_case("R4", 12'h000);
    ar_send(32'h0, 8'd15, 3'd2, 2'b00); ar_send(32'h0, 8'd255, 3'd0, 2'b01); end_case;
    begin_case("R4", 12'h008); ar_send(32'h0, 8'd16, 3'd2, 2'b00); end_case;
    begin_case("R4", 12'h008); aw_send(32'h0, 8'd2, 3'd2, 2'b10); end_case;

    // R5 WRAP alignment
    begin_case("R5", 12'h000); aw_send(32'h4, 8'd3, 3'd2, 2'b10); end_case;
    begin_case("R5", 12'h010); aw_send(32'h2, 8'd3, 3'd2, 2'b10); end_case;

    // R6 size beyond 4-byte bus
    begin_case("R6", 12'h020); ar_send(32'h0, 8'd0, 3'd3, 2'b01); end_case;

    // R7 4KB boundary: ending exactly on it is legal, one beat more is not
    begin_case("R7", 12'h000); aw_send(32'hFF0, 8'd3, 3'd2, 2'b01); end_case;
    begin_case("R7", 12'h040); aw_send(32'h1FF0, 8'd4, 3'd2, 2'b01); end_case;

    // R8 write last too early
    begin_case("R8", 12'h080); aw_send(32'h0, 8'd3, 3'd2, 2'b01); w_burst(2); end_case;
    // R8 interleaved data: first closed burst too short for first address
    begin_case("R8", 12'h080);
    aw_send(32'h0, 8'd1, 3'd2, 2'b01); aw_send(32'h100, 8'd1, 3'd2, 2'b01); w_burst(1); end_case;

    // R10 read data without address
    begin_case("R10", 12'h200); r_beat(1); end_case;

    // R11 last missing on final beat, and last too early
    begin_case("R11", 12'h400); ar_send(32'h0, 8'd1, 3'd2, 2'b01); r_beat(0); r_beat(0); end_case;
    begin_case("R11", 12'h400); ar_send(32'h0, 8'd2, 3'd2, 2'b01); r_beat(1); end_case;

    // R12 fifth outstanding write address with DEPTH=4
    begin_case("R12", 12'h000);
    for (int i = 0; i < 4; i++) aw_send(32'(i*64), 8'd0, 3'd2, 2'b01);
    idle(2); check("R12 four tracked", 32'(err_flags), 0);
    exp_flags = 12'h800; aw_send(32'h400, 8'd0, 3'd2, 2'b01);
    end_case;

    // R13 first code and stickiness across a later error
    begin_case("R13", 12'h004);
    ar_send(32'h0, 8'd0, 3'd2, 2'b11); idle(2);
    check("R13 first code", 32'(err_first), 2);
    exp_flags = 12'h005;
    @(negedge clk); ar_valid = 1; ar_ready = 0;
    @(negedge clk); ar_valid = 0;
    end_case;
    check("R13 code kept", 32'(err_first), 2);
    check("R13 any", 32'(err_any), 1);

    live = 0; done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule